// File: doc/BRIEF.md
# Dispatch Admission and In-Order Retirement Unit

This block sits between a queue of decoded instructions and the out-of-order back end of a core. Each cycle the source presents up to `DISP_W` instructions on parallel lanes, lane 0 being the oldest. The block admits the longest oldest-first run of lanes that fits every resource it guards: the lane count, free reorder-buffer slots counted in micro-ops, free physical rename registers, and the "full" flag of the scheduler each instruction targets. An admitted instruction receives a reorder-buffer tag, which is handed back to the source on the same lane.

The reorder buffer is circular. An instruction occupies as many consecutive slots as it has micro-ops, and its tag is the index of its first slot. Completion tags from the execution side mark entries finished. Up to `RET_W` finished instructions leave per cycle, always from the oldest end and in program order. Their slots and rename registers go back to the pools and can be used from the next cycle on. A pool size of zero configures an unlimited register supply.

Top module: `dispatch_rob`

## Requirements
- R1: `in_ready[i]` is high only when `in_valid[i]` is high and every older lane `j < i` is also admitted. The first lane that fails blocks all younger lanes in that cycle, and no more than `DISP_W` instructions are admitted per cycle.
- R2: Lane micro-op counts are encoded on `in_uops` as count minus one, 2 bits per lane, giving 1 to 4. The tag of an admitted lane equals the tail pointer plus the micro-ops of the older lanes admitted in the same cycle, modulo `ROB_DEPTH`. The first tag after reset is 0.
- R3: A lane is admitted only if the running micro-op total of the lanes admitted up to and including it is no larger than `ROB_DEPTH` minus the occupancy at the start of the cycle.
- R4: A lane whose scheduler index (`in_sched`, 1 bit per lane by default) selects a set bit of `sched_full` is not admitted, and neither is any younger lane.
- R5: With `PRF_SIZE > 0`, the running count of admitted lanes with `in_dst` set must not exceed the free rename registers at the start of the cycle. With `PRF_SIZE = 0` the register check always passes.
- R6: `ret_valid[0]` is high only if the oldest entry is completed. `ret_valid[k]` is high only if `ret_valid[k-1]` is high and the entry that follows is completed. `ret_tag[k]` gives the retired tag.
- R7: A completion presented in cycle t makes the entry retirable from cycle t+1. Slots and registers freed by a retirement in cycle t are available for admission from cycle t+1.
- R8: `ret_dst[k]` is high when retirement k returns a rename register to the free pool. The pool count rises by that amount.
- R9: Reset empties the reorder buffer, clears all retire outputs and refills the register pool completely. This holds when reset is applied in the middle of traffic as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | DISP_W | Lane holds an instruction |
| in_uops | input | 2*DISP_W | Micro-op count minus one per lane |
| in_dst | input | DISP_W | Lane needs one destination register |
| in_sched | input | DISP_W*SCHED_W | Target scheduler index per lane |
| in_ready | output | DISP_W | Lane admitted this cycle |
| in_tag | output | DISP_W*TAG_W | Tag assigned to each admitted lane |
| sched_full | input | NSCHED | Per-scheduler full flag |
| cmp_valid | input | NCOMP | Completion report valid |
| cmp_tag | input | NCOMP*TAG_W | Tag of completed entry |
| ret_valid | output | RET_W | Retirement slot active |
| ret_tag | output | RET_W*TAG_W | Tag of retiring entry |
| ret_dst | output | RET_W | Retirement frees one rename register |

## Verification
Every cycle the checker confirms the structural laws: the ready lanes form a prefix of the valid lanes, no ready lane targets a full scheduler, retire slots fill contiguously from slot 0, occupancy and register use stay within their bounds, and occupancy does not move in a cycle without admission or retirement. The exact admission boundary is shown only by the bench's long mixed-traffic sweeps, which compare cycle by cycle against an arithmetic model. These sweeps cover the micro-op total crossing the free-slot count, the register pool running dry, the tag arithmetic with wrap-around, the one-cycle delay between completion and retirement, a reset during traffic, and the unlimited-pool configuration.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int UCODE_W = 2;   // encoded micro-op count width (count - 1)
  localparam int UCNT_W  = 3;   // decoded micro-op count width (1..4)
endpackage

// File: rtl/dr_admit.sv
module dr_admit
  import dr_pkg::*;
#(
  parameter int DISP_W  = 2,
  parameter int NSCHED  = 2,
  parameter int SCHED_W = 1,
  parameter int TAG_W   = 4,
  parameter int OCC_W   = 5,
  parameter int REG_W   = 5
) (
  input  logic [DISP_W-1:0]                 lane_valid,
  input  logic [DISP_W-1:0][UCNT_W-1:0]     lane_uops,
  input  logic [DISP_W-1:0]                 lane_dst,
  input  logic [DISP_W-1:0][SCHED_W-1:0]    lane_sched,
  input  logic [NSCHED-1:0]                 sched_full,
  input  logic [OCC_W-1:0]                  rob_room,
  input  logic [REG_W-1:0]                  reg_room,
  input  logic [TAG_W-1:0]                  tail,
  output logic [DISP_W-1:0]                 admit,
  output logic [DISP_W-1:0][TAG_W-1:0]      lane_tag,
  output logic [OCC_W-1:0]                  add_uops,
  output logic [REG_W-1:0]                  add_dst
);
  always_comb begin
    logic        go;
    logic        fit;
    logic [31:0] cu;
    logic [31:0] cd;
    logic [31:0] cu_n;
    logic [31:0] cd_n;
    go = 1'b1;
    cu = '0;
    cd = '0;
    for (int i = 0; i < DISP_W; i++) begin
      lane_tag[i] = tail + TAG_W'(cu);
      cu_n = cu + 32'(lane_uops[i]);
      cd_n = cd + 32'(lane_dst[i]);
      fit  = (cu_n <= 32'(rob_room)) && (cd_n <= 32'(reg_room)) &&
             !sched_full[lane_sched[i]];
      go       = go && lane_valid[i] && fit;
      admit[i] = go;
      if (go) begin
        cu = cu_n;
        cd = cd_n;
      end
    end
    add_uops = OCC_W'(cu);
    add_dst  = REG_W'(cd);
  end
endmodule

// File: rtl/dr_rob.sv
module dr_rob
  import dr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 4,
  parameter int OCC_W  = 5,
  parameter int REG_W  = 5,
  parameter int DISP_W = 2,
  parameter int NCOMP  = 2,
  parameter int RET_W  = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [DISP_W-1:0]                admit,
  input  logic [DISP_W-1:0][TAG_W-1:0]     lane_tag,
  input  logic [DISP_W-1:0][UCNT_W-1:0]    lane_uops,
  input  logic [DISP_W-1:0]                lane_dst,
  input  logic [OCC_W-1:0]                 add_uops,
  input  logic [NCOMP-1:0]                 cmp_valid,
  input  logic [NCOMP-1:0][TAG_W-1:0]      cmp_tag,
  output logic [TAG_W-1:0]                 tail,
  output logic [OCC_W-1:0]                 occ,
  output logic [RET_W-1:0]                 ret_valid,
  output logic [RET_W-1:0][TAG_W-1:0]      ret_tag,
  output logic [RET_W-1:0]                 ret_dst,
  output logic [REG_W-1:0]                 rel_dst
);
  logic [DEPTH-1:0]              vld_q, vld_d;
  logic [DEPTH-1:0]              done_q, done_d;
  logic [DEPTH-1:0]              dst_q, dst_d;
  logic [DEPTH-1:0][UCNT_W-1:0]  uops_q, uops_d;
  logic [TAG_W-1:0]              head_q, head_d, tail_q, tail_d;
  logic [OCC_W-1:0]              occ_q, occ_d;
  logic [OCC_W-1:0]              rel_uops;

  // retirement walk from the oldest entry
  always_comb begin
    logic [TAG_W-1:0] cur;
    logic             more;
    cur      = head_q;
    more     = 1'b1;
    rel_uops = '0;
    rel_dst  = '0;
    for (int k = 0; k < RET_W; k++) begin
      ret_valid[k] = more && vld_q[cur] && done_q[cur];
      ret_tag[k]   = cur;
      ret_dst[k]   = ret_valid[k] && dst_q[cur];
      if (ret_valid[k]) begin
        rel_uops = rel_uops + OCC_W'(uops_q[cur]);
        rel_dst  = rel_dst + REG_W'(dst_q[cur]);
      end
      cur  = cur + TAG_W'(uops_q[cur]);
      more = ret_valid[k];
    end
  end

  // entry state next values
  always_comb begin
    vld_d  = vld_q;
    done_d = done_q;
    dst_d  = dst_q;
    uops_d = uops_q;
    for (int c = 0; c < NCOMP; c++) begin
      if (cmp_valid[c]) done_d[cmp_tag[c]] = 1'b1;
    end
    for (int k = 0; k < RET_W; k++) begin
      if (ret_valid[k]) vld_d[ret_tag[k]] = 1'b0;
    end
    for (int i = 0; i < DISP_W; i++) begin
      if (admit[i]) begin
        vld_d[lane_tag[i]]  = 1'b1;
        done_d[lane_tag[i]] = 1'b0;
        dst_d[lane_tag[i]]  = lane_dst[i];
        uops_d[lane_tag[i]] = lane_uops[i];
      end
    end
    head_d = head_q + TAG_W'(rel_uops);
    tail_d = tail_q + TAG_W'(add_uops);
    occ_d  = occ_q + add_uops - rel_uops;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      done_q <= '0;
      dst_q  <= '0;
      uops_q <= '0;
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      done_q <= done_d;
      dst_q  <= dst_d;
      uops_q <= uops_d;
      head_q <= head_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
    end
  end

  assign tail = tail_q;
  assign occ  = occ_q;
endmodule

// File: rtl/dr_regpool.sv
module dr_regpool #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] alloc_cnt,
  input  logic [REG_W-1:0] release_cnt,
  output logic [REG_W-1:0] in_use
);
  logic [REG_W-1:0] use_q, use_d;
  logic             upd;

  always_comb begin
    upd   = (alloc_cnt != '0) || (release_cnt != '0);
    use_d = use_q + alloc_cnt - release_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   use_q <= '0;
    else if (upd) use_q <= use_d;
  end

  assign in_use = use_q;
endmodule

// File: rtl/dispatch_rob.sv
module dispatch_rob
  import dr_pkg::*;
#(
  parameter int DISP_W    = 2,
  parameter int ROB_DEPTH = 16,
  parameter int PRF_SIZE  = 8,
  parameter int NSCHED    = 2,
  parameter int NCOMP     = 2,
  parameter int RET_W     = 2,
  localparam int TAG_W    = $clog2(ROB_DEPTH),
  localparam int OCC_W    = $clog2(ROB_DEPTH + 1),
  localparam int SCHED_W  = (NSCHED > 1) ? $clog2(NSCHED) : 1,
  localparam int REG_MAX  = (PRF_SIZE > ROB_DEPTH) ? PRF_SIZE : ROB_DEPTH,
  localparam int REG_W    = $clog2(REG_MAX + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DISP_W-1:0]           in_valid,
  input  logic [UCODE_W*DISP_W-1:0]   in_uops,
  input  logic [DISP_W-1:0]           in_dst,
  input  logic [DISP_W*SCHED_W-1:0]   in_sched,
  output logic [DISP_W-1:0]           in_ready,
  output logic [DISP_W*TAG_W-1:0]     in_tag,
  input  logic [NSCHED-1:0]           sched_full,
  input  logic [NCOMP-1:0]            cmp_valid,
  input  logic [NCOMP*TAG_W-1:0]      cmp_tag,
  output logic [RET_W-1:0]            ret_valid,
  output logic [RET_W*TAG_W-1:0]      ret_tag,
  output logic [RET_W-1:0]            ret_dst
);
  logic [DISP_W-1:0][UCNT_W-1:0]   lane_uops;
  logic [DISP_W-1:0][SCHED_W-1:0]  lane_sched;
  logic [DISP_W-1:0][TAG_W-1:0]    lane_tag;
  logic [NCOMP-1:0][TAG_W-1:0]     cmp_tag_v;
  logic [RET_W-1:0][TAG_W-1:0]     ret_tag_v;
  logic [TAG_W-1:0]                tail;
  logic [OCC_W-1:0]                occ, rob_room, add_uops;
  logic [REG_W-1:0]                add_dst, rel_dst, in_use, reg_room;

  for (genvar i = 0; i < DISP_W; i++) begin : g_lane
    assign lane_uops[i]  = {1'b0, in_uops[UCODE_W*i +: UCODE_W]} + UCNT_W'(1);
    assign lane_sched[i] = in_sched[SCHED_W*i +: SCHED_W];
    assign in_tag[TAG_W*i +: TAG_W] = lane_tag[i];
  end
  for (genvar c = 0; c < NCOMP; c++) begin : g_cmp
    assign cmp_tag_v[c] = cmp_tag[TAG_W*c +: TAG_W];
  end
  for (genvar k = 0; k < RET_W; k++) begin : g_ret
    assign ret_tag[TAG_W*k +: TAG_W] = ret_tag_v[k];
  end

  assign rob_room = OCC_W'(ROB_DEPTH) - occ;

  if (PRF_SIZE == 0) begin : g_unlim
    assign reg_room = '1;
  end else begin : g_lim
    assign reg_room = REG_W'(PRF_SIZE) - in_use;
  end

  dr_admit #(
    .DISP_W(DISP_W), .NSCHED(NSCHED), .SCHED_W(SCHED_W),
    .TAG_W(TAG_W), .OCC_W(OCC_W), .REG_W(REG_W)
  ) u_admit (
    .lane_valid(in_valid), .lane_uops(lane_uops), .lane_dst(in_dst),
    .lane_sched(lane_sched), .sched_full(sched_full), .rob_room(rob_room),
    .reg_room(reg_room), .tail(tail), .admit(in_ready), .lane_tag(lane_tag),
    .add_uops(add_uops), .add_dst(add_dst)
  );

  dr_rob #(
    .DEPTH(ROB_DEPTH), .TAG_W(TAG_W), .OCC_W(OCC_W), .REG_W(REG_W),
    .DISP_W(DISP_W), .NCOMP(NCOMP), .RET_W(RET_W)
  ) u_rob (
    .clk(clk), .rst_n(rst_n), .admit(in_ready), .lane_tag(lane_tag),
    .lane_uops(lane_uops), .lane_dst(in_dst), .add_uops(add_uops),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag_v), .tail(tail), .occ(occ),
    .ret_valid(ret_valid), .ret_tag(ret_tag_v), .ret_dst(ret_dst),
    .rel_dst(rel_dst)
  );

  dr_regpool #(.REG_W(REG_W)) u_pool (
    .clk(clk), .rst_n(rst_n), .alloc_cnt(add_dst), .release_cnt(rel_dst),
    .in_use(in_use)
  );
endmodule

// File: rtl/dr_checker.sv
module dr_checker #(
  parameter int DISP_W    = 2,
  parameter int ROB_DEPTH = 16,
  parameter int PRF_SIZE  = 8,
  parameter int NSCHED    = 2,
  parameter int RET_W     = 2,
  localparam int OCC_W    = $clog2(ROB_DEPTH + 1),
  localparam int SCHED_W  = (NSCHED > 1) ? $clog2(NSCHED) : 1,
  localparam int REG_MAX  = (PRF_SIZE > ROB_DEPTH) ? PRF_SIZE : ROB_DEPTH,
  localparam int REG_W    = $clog2(REG_MAX + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [DISP_W-1:0]         in_valid,
  input logic [DISP_W-1:0]         in_ready,
  input logic [DISP_W*SCHED_W-1:0] in_sched,
  input logic [NSCHED-1:0]         sched_full,
  input logic [RET_W-1:0]          ret_valid,
  input logic [OCC_W-1:0]          occ,
  input logic [REG_W-1:0]          in_use
);
  for (genvar i = 0; i < DISP_W; i++) begin : g_l
    // R1: admission needs a valid lane
    p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> in_valid[i]);
    // R4: a full scheduler blocks its lane
    p_sched_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> !sched_full[in_sched[SCHED_W*i +: SCHED_W]]);
    if (i > 0) begin : g_pre
      // R1: program-order prefix
      p_prefix_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready[i] |-> in_ready[i-1]);
    end
  end
  for (genvar k = 1; k < RET_W; k++) begin : g_r
    // R6: retire slots fill in order
    p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ret_valid[k] |-> ret_valid[k-1]);
  end
  // R3: occupancy never exceeds the buffer
  p_occ_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(ROB_DEPTH));
  // R7: occupancy moves only on admission or retirement
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready == '0 && ret_valid == '0) |=> $stable(occ));
  if (PRF_SIZE > 0) begin : g_pool
    // R5: register use stays within the pool
    p_pool_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_use <= REG_W'(PRF_SIZE));
  end
endmodule

bind dispatch_rob dr_checker #(
  .DISP_W(DISP_W), .ROB_DEPTH(ROB_DEPTH), .PRF_SIZE(PRF_SIZE),
  .NSCHED(NSCHED), .RET_W(RET_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sched(in_sched), .sched_full(sched_full), .ret_valid(ret_valid),
  .occ(occ), .in_use(in_use)
);

// File: tb/tb_dispatch_rob.sv
`timescale 1ns/1ps
module tb_dispatch_rob;
  localparam int DEPTH = 16;
  localparam int PRF   = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] in_valid, in_dst, in_sched, in_ready, sched_full, cmp_valid;
  logic [3:0] in_uops;
  logic [7:0] in_tag, cmp_tag, ret_tag;
  logic [1:0] ret_valid, ret_dst;

  logic [1:0] u_valid, u_dst, u_ready, u_rv, u_rd;
  logic [7:0] u_tag, u_rt;

  int errors = 0;
  int checks = 0;

  int q_tag[$], q_u[$], q_d[$];
  bit q_done[$];
  int m_tail, m_occ, m_use;

  always #4 clk = ~clk;

  dispatch_rob dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
    .in_dst(in_dst), .in_sched(in_sched), .in_ready(in_ready), .in_tag(in_tag),
    .sched_full(sched_full), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_dst(ret_dst)
  );

  dispatch_rob #(.PRF_SIZE(0)) dut_u (
    .clk(clk), .rst_n(rst_n), .in_valid(u_valid), .in_uops(4'b0000),
    .in_dst(u_dst), .in_sched(2'b00), .in_ready(u_ready), .in_tag(u_tag),
    .sched_full(2'b00), .cmp_valid(2'b00), .cmp_tag(8'h00),
    .ret_valid(u_rv), .ret_tag(u_rt), .ret_dst(u_rd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    q_tag.delete(); q_u.delete(); q_d.delete(); q_done.delete();
    m_tail = 0; m_occ = 0; m_use = 0;
  endtask

  // one cycle of mixed traffic; knobs in percent
  task automatic step(input int pv, input int pd, input int pf, input int pc);
    int  cand[$];
    int  pend[$];
    int  cu, cd, nu, nd, nr, u, d, s;
    bit  go, fit;
    bit [1:0] er, ev;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      in_valid[i] = ($urandom_range(99) < pv);
      in_uops[2*i +: 2] = 2'($urandom_range(3));
      in_dst[i] = ($urandom_range(99) < pd);
      in_sched[i] = 1'($urandom_range(1));
      sched_full[i] = ($urandom_range(99) < pf);
    end
    cmp_valid = '0;
    cmp_tag   = '0;
    foreach (q_done[j]) if (!q_done[j]) cand.push_back(j);
    for (int c = 0; c < 2; c++) begin
      if (cand.size() > 0 && $urandom_range(99) < pc) begin
        int idx;
        idx = $urandom_range(cand.size() - 1);
        cmp_valid[c] = 1'b1;
        cmp_tag[4*c +: 4] = 4'(q_tag[cand[idx]]);
        pend.push_back(cand[idx]);
        cand.delete(idx);
      end
    end
    #1;
    // R1 R3 R4 R5: expected admission
    go = 1; cu = 0; cd = 0;
    for (int i = 0; i < 2; i++) begin
      u  = int'(in_uops[2*i +: 2]) + 1;
      d  = int'(in_dst[i]);
      s  = int'(in_sched[i]);
      nu = cu + u;
      nd = cd + d;
      fit = (nu <= DEPTH - m_occ) && (nd <= PRF - m_use) && !sched_full[s];
      go = go && in_valid[i] && fit;
      er[i] = go;
      if (go) begin
        // R2: tag = tail + older admitted micro-ops
        chk(in_tag[4*i +: 4] == 4'((m_tail + cu) % DEPTH), "R2 tag",
            int'(in_tag[4*i +: 4]), (m_tail + cu) % DEPTH);
        cu = nu; cd = nd;
      end
    end
    chk(in_ready == er, "R1/R3/R4/R5 ready", int'(in_ready), int'(er));
    // R6 R7 R8: expected retirement
    nr = 0;
    for (int k = 0; k < 2; k++) begin
      ev[k] = (k < q_tag.size()) && q_done[k] && (k == 0 || ev[0]);
      if (ev[k]) begin
        nr++;
        chk(ret_tag[4*k +: 4] == 4'(q_tag[k]), "R6 ret_tag",
            int'(ret_tag[4*k +: 4]), q_tag[k]);
        chk(ret_dst[k] == 1'(q_d[k]), "R8 ret_dst", int'(ret_dst[k]), q_d[k]);
      end
    end
    chk(ret_valid == ev, "R6/R7 ret_valid", int'(ret_valid), int'(ev));
    // model update
    foreach (pend[p]) q_done[pend[p]] = 1'b1;
    for (int k = 0; k < nr; k++) begin
      m_occ -= q_u[0];
      m_use -= q_d[0];
      void'(q_tag.pop_front()); void'(q_u.pop_front());
      void'(q_d.pop_front()); void'(q_done.pop_front());
    end
    cu = 0;
    for (int i = 0; i < 2; i++) begin
      if (er[i]) begin
        u = int'(in_uops[2*i +: 2]) + 1;
        q_tag.push_back((m_tail + cu) % DEPTH);
        q_u.push_back(u);
        q_d.push_back(int'(in_dst[i]));
        q_done.push_back(1'b0);
        cu += u;
        m_use += int'(in_dst[i]);
      end
    end
    m_occ += cu;
    m_tail = (m_tail + cu) % DEPTH;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0;
    in_valid = '0; in_uops = '0; in_dst = '0; in_sched = '0;
    sched_full = '0; cmp_valid = '0; cmp_tag = '0;
    u_valid = '0; u_dst = '0;
    model_clear();
    repeat (3) @(negedge clk);
    // R9: retire outputs idle in reset
    chk(ret_valid == 2'b00, "R9 reset ret_valid", int'(ret_valid), 0);
    rst_n = 1'b1;

    // R5: unlimited pool, 16 single-uop instructions with destinations
    for (int c = 0; c < 9; c++) begin
      @(negedge clk);
      u_valid = 2'b11; u_dst = 2'b11;
      #1;
      if (c < 8) chk(u_ready == 2'b11, "R5 unlimited pool", int'(u_ready), 3);
      else       chk(u_ready == 2'b00, "R3 unlimited full ROB", int'(u_ready), 0);
    end
    @(negedge clk);
    u_valid = '0;

    // R3: fill with little completion
    for (int n = 0; n < 1500; n++) step(90, 10, 0, 8);
    // R5: destination-heavy traffic
    for (int n = 0; n < 1500; n++) step(90, 90, 0, 25);
    // R4: schedulers often full
    for (int n = 0; n < 1500; n++) step(90, 40, 40, 40);
    // R9: reset in the middle of traffic
    @(negedge clk);
    rst_n = 1'b0; in_valid = '0; cmp_valid = '0;
    #1;
    chk(ret_valid == 2'b00, "R9 mid reset ret_valid", int'(ret_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    // R6 R7: fast completion, drains through both retire slots
    for (int n = 0; n < 1500; n++) step(70, 50, 5, 90);
    // R9: pool refilled and ROB empty: full draw admitted
    for (int n = 0; n < 300; n++) step(0, 0, 0, 100);
    @(negedge clk);
    in_valid = 2'b11; in_uops = 4'b1111; in_dst = 2'b11;
    in_sched = '0; sched_full = '0; cmp_valid = '0;
    #1;
    chk(in_ready == 2'b11, "R9 drained state admits", int'(in_ready), 3);
    @(negedge clk);
    in_valid = '0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule